// File: doc/BRIEF.md
# Outbound Local-to-PCI Address Window Translator

This block sits between a processor's local bus and a PCI host interface. It decides whether a local-bus address falls into one of a small set of programmable outbound windows and, if it does, produces the PCI bus address that the access should carry. Software programs each window through a 32-bit register port. It sets a 64-bit local base, a 64-bit PCI base and a 32-bit size/enable word. Each 64-bit base is reached as two separate 32-bit halves.

The lookup path is purely combinational. A 64-bit local address goes in, and a hit flag, the index of the winning window and the translated 64-bit PCI address come out in the same cycle. A register write lands on the clock edge. From the next cycle on, every lookup uses the new values. Window sizes are written as a mask: the set upper bits of the size word select the window size, and bit 0 switches the window on.

Top module: `obwin_xlate`

## Requirements
- R1: With the default parameters there are three windows. Windows 0 and 1 each have five 32-bit registers at byte offsets base+0x00 (local base bits 31:0), base+0x04 (local base bits 63:32), base+0x08 (size/enable), base+0x0C (PCI base bits 31:0) and base+0x10 (PCI base bits 63:32). The base is 0x68 for window 0 and 0x7C for window 1. Window 2 has only a size/enable register, at 0x90. Each register reads back the last value written to it.
- R2: A write to a low-half register replaces only bits 31:0 of its 64-bit base, and a write to a high-half register replaces only bits 63:32. The other half keeps its value.
- R3: A window whose size/enable bit 0 is 0 never produces a hit.
- R4: A window spans 2^32 minus the size/enable word with bit 0 cleared, counted in bytes. Example: 0xFFFF0001 gives 64 KiB. A word of 0x00000001 gives 4 GiB.
- R5: A window hits when (lookup address − local base) mod 2^64 is below the window span. On a hit, lk_pci_addr is (PCI base + that offset) mod 2^64. Window 2 always has local base 0 and PCI base 0.
- R6: A register write takes effect on lookups from the cycle after the clock edge that captured it.
- R7: Reset clears every window register to zero, so every window is disabled and every register reads 0.
- R8: When several enabled windows hit, the one with the lowest index is reported.
- R9: A read of an offset that maps to no register returns 0, and a write to such an offset changes no register and no lookup result.
- R10: reg_rdata shows the register addressed in the previous cycle's read, one cycle after reg_rd is high. In a cycle after one without a read, it is 0.
- R11: When no window hits, lk_hit is 0, lk_idx is 0 and lk_pci_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | OFF_W (8) | Register byte offset |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, one cycle after reg_rd |
| lk_addr | input | 2*DW (64) | Local-bus address to translate |
| lk_hit | output | 1 | Address falls inside an enabled window |
| lk_idx | output | IW (2) | Index of the winning window |
| lk_pci_addr | output | 2*DW (64) | Translated PCI address |

## Verification
The bench probes window edges on both sides. It checks the last byte inside a window and the first byte past it, and the byte just below the base. An off-by-one in the span arithmetic would turn these into a stray hit or a lost hit. It overlaps two windows and then disables the lower one. A reversed priority, or an enable bit that is ignored, would report the wrong index or a phantom hit. It rewrites one half of a base and reads the other half back, which exposes a write that clobbers the full 64 bits. A window that wraps past 2^64 and a zero mask (4 GiB span) catch a span computed only 32 bits wide. Stray writes to unmapped offsets would show up as altered read-back or lookup results.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

   // Register slots inside one full window, in address order
   localparam int SLOTS     = 5;
   localparam int SL_LOC_LO = 0;
   localparam int SL_LOC_HI = 1;
   localparam int SL_CTL    = 2;
   localparam int SL_PCI_LO = 3;
   localparam int SL_PCI_HI = 4;

   // Byte offset of slot s in full window w
   function automatic int slot_offset(int win0, int stride, int w, int s);
      return win0 + w * stride + 4 * s;
   endfunction

   // Byte offset of the size/enable register of size-only window w
   function automatic int szonly_offset(int sz0, int full, int w);
      return sz0 + 4 * (w - full);
   endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
   import obwin_pkg::*;
#(
   parameter int NWIN     = 3,
   parameter int FULL     = 2,
   parameter int DW       = 32,
   parameter int OFF_W    = 8,
   parameter int WIN0_OFF = 'h68,
   parameter int STRIDE   = 'h14,
   parameter int SZ_OFF   = 'h90
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_wr,
   input  logic                           reg_rd,
   input  logic [OFF_W-1:0]               reg_addr,
   input  logic [DW-1:0]                  reg_wdata,
   output logic [DW-1:0]                  reg_rdata,
   output logic [NWIN-1:0][2*DW-1:0]      loc_base,
   output logic [NWIN-1:0][2*DW-1:0]      pci_base,
   output logic [NWIN-1:0][DW-1:0]        ctl
);

   logic [SLOTS-1:0] sel  [NWIN];
   logic [DW-1:0]    sval [NWIN][SLOTS];
   logic [DW-1:0]    rd_mux;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      if (w < FULL) begin : g_full
         logic [2*DW-1:0] loc_q;
         logic [2*DW-1:0] pci_q;
         logic [DW-1:0]   ctl_q;

         for (genvar s = 0; s < SLOTS; s++) begin : g_sel
            assign sel[w][s] = (reg_addr == OFF_W'(slot_offset(WIN0_OFF, STRIDE, w, s)));
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               loc_q <= '0;
               pci_q <= '0;
               ctl_q <= '0;
            end else if (reg_wr) begin
               if (sel[w][SL_LOC_LO]) loc_q[DW-1:0]    <= reg_wdata;
               if (sel[w][SL_LOC_HI]) loc_q[2*DW-1:DW] <= reg_wdata;
               if (sel[w][SL_CTL])    ctl_q            <= reg_wdata;
               if (sel[w][SL_PCI_LO]) pci_q[DW-1:0]    <= reg_wdata;
               if (sel[w][SL_PCI_HI]) pci_q[2*DW-1:DW] <= reg_wdata;
            end
         end

         assign sval[w][SL_LOC_LO] = loc_q[DW-1:0];
         assign sval[w][SL_LOC_HI] = loc_q[2*DW-1:DW];
         assign sval[w][SL_CTL]    = ctl_q;
         assign sval[w][SL_PCI_LO] = pci_q[DW-1:0];
         assign sval[w][SL_PCI_HI] = pci_q[2*DW-1:DW];
         assign loc_base[w] = loc_q;
         assign pci_base[w] = pci_q;
         assign ctl[w]      = ctl_q;
      end else begin : g_szonly
         logic [DW-1:0] ctl_q;

         for (genvar s = 0; s < SLOTS; s++) begin : g_sel
            if (s == SL_CTL) begin : g_ctl
               assign sel[w][s]  = (reg_addr == OFF_W'(szonly_offset(SZ_OFF, FULL, w)));
               assign sval[w][s] = ctl_q;
            end else begin : g_none
               assign sel[w][s]  = 1'b0;
               assign sval[w][s] = '0;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       ctl_q <= '0;
            else if (reg_wr && sel[w][SL_CTL]) ctl_q <= reg_wdata;
         end

         assign loc_base[w] = '0;
         assign pci_base[w] = '0;
         assign ctl[w]      = ctl_q;
      end
   end

   // Offsets never alias, so an OR of the selected slots is the read mux
   always_comb begin
      rd_mux = '0;
      for (int w = 0; w < NWIN; w++) begin
         for (int s = 0; s < SLOTS; s++) begin
            if (sel[w][s]) rd_mux = rd_mux | sval[w][s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
      else             reg_rdata <= '0;
   end

endmodule

// File: rtl/obwin_match.sv
module obwin_match #(
   parameter int DW = 32,
   parameter int AW = 64
)(
   input  logic [AW-1:0] lk_addr,
   input  logic [AW-1:0] loc_base,
   input  logic [AW-1:0] pci_base,
   input  logic [DW-1:0] ctl,
   output logic          hit,
   output logic [AW-1:0] xlat
);

   localparam logic [DW:0] FULL_SPAN = {1'b1, {DW{1'b0}}};

   logic [DW:0]   span;
   logic [AW-1:0] off;

   // Span is 2^DW minus the mask; a zero mask gives the full 2^DW
   assign span = FULL_SPAN - {1'b0, ctl[DW-1:1], 1'b0};
   assign off  = lk_addr - loc_base;
   assign hit  = ctl[0] && (off < {{(AW-DW-1){1'b0}}, span});
   assign xlat = pci_base + off;

endmodule

// File: rtl/obwin_prio.sv
module obwin_prio #(
   parameter int NWIN = 3,
   parameter int AW   = 64,
   parameter int IW   = 2
)(
   input  logic [NWIN-1:0]         hit_vec,
   input  logic [NWIN-1:0][AW-1:0] xlat,
   output logic                    any,
   output logic [IW-1:0]           idx,
   output logic [AW-1:0]           addr
);

   // Scan downward so the lowest index overrides
   always_comb begin
      any  = 1'b0;
      idx  = '0;
      addr = '0;
      for (int w = NWIN - 1; w >= 0; w--) begin
         if (hit_vec[w]) begin
            any  = 1'b1;
            idx  = IW'(w);
            addr = xlat[w];
         end
      end
   end

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
   import obwin_pkg::*;
#(
   parameter int NWIN        = 3,
   parameter int FULL_WINS   = 2,
   parameter int DW          = 32,
   parameter int OFF_W       = 8,
   parameter int WIN0_OFF    = 'h68,
   parameter int WIN_STRIDE  = 'h14,
   parameter int SZ_ONLY_OFF = 'h90,
   localparam int AW = 2 * DW,
   localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [OFF_W-1:0] reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic [AW-1:0]    lk_addr,
   output logic             lk_hit,
   output logic [IW-1:0]    lk_idx,
   output logic [AW-1:0]    lk_pci_addr
);

   // Elaboration-time parameter checks
   if (NWIN < 1 || FULL_WINS > NWIN) begin : g_chk_count
      $error("obwin_xlate: FULL_WINS must not exceed NWIN, NWIN >= 1");
   end
   if (DW < 2) begin : g_chk_dw
      $error("obwin_xlate: DW must be at least 2");
   end
   if (WIN_STRIDE < 4 * SLOTS) begin : g_chk_stride
      $error("obwin_xlate: WIN_STRIDE too small for the register slots");
   end
   if (FULL_WINS < NWIN && WIN0_OFF + FULL_WINS * WIN_STRIDE > SZ_ONLY_OFF) begin : g_chk_overlap
      $error("obwin_xlate: size-only registers overlap full windows");
   end
   if (SZ_ONLY_OFF + 4 * (NWIN - FULL_WINS) > 2 ** OFF_W ||
       WIN0_OFF + FULL_WINS * WIN_STRIDE > 2 ** OFF_W) begin : g_chk_space
      $error("obwin_xlate: register offsets exceed OFF_W");
   end

   logic [NWIN-1:0][AW-1:0] loc_base;
   logic [NWIN-1:0][AW-1:0] pci_base;
   logic [NWIN-1:0][DW-1:0] ctl;
   logic [NWIN-1:0][AW-1:0] win_xlat;
   logic [NWIN-1:0]         win_hit;
   logic [NWIN-1:0]         win_en;

   obwin_regs #(
      .NWIN(NWIN), .FULL(FULL_WINS), .DW(DW), .OFF_W(OFF_W),
      .WIN0_OFF(WIN0_OFF), .STRIDE(WIN_STRIDE), .SZ_OFF(SZ_ONLY_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .loc_base(loc_base), .pci_base(pci_base), .ctl(ctl)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_match
      obwin_match #(.DW(DW), .AW(AW)) u_match (
         .lk_addr(lk_addr), .loc_base(loc_base[w]), .pci_base(pci_base[w]),
         .ctl(ctl[w]), .hit(win_hit[w]), .xlat(win_xlat[w])
      );
      assign win_en[w] = ctl[w][0];
   end

   obwin_prio #(.NWIN(NWIN), .AW(AW), .IW(IW)) u_prio (
      .hit_vec(win_hit), .xlat(win_xlat),
      .any(lk_hit), .idx(lk_idx), .addr(lk_pci_addr)
   );

endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk #(
   parameter int NWIN = 3,
   parameter int DW   = 32,
   parameter int IW   = 2
)(
   input logic            clk,
   input logic            rst_n,
   input logic            reg_rd,
   input logic [DW-1:0]   reg_rdata,
   input logic            lk_hit,
   input logic [IW-1:0]   lk_idx,
   input logic [2*DW-1:0] lk_pci_addr,
   input logic [NWIN-1:0] win_en,
   input logic [NWIN-1:0] win_hit
);

   logic [NWIN-1:0] below;
   assign below = (NWIN'(1) << lk_idx) - NWIN'(1);

   AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> win_en[lk_idx]); // R3

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (win_hit[lk_idx] && ((win_hit & below) == '0))); // R8

   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_idx == '0 && lk_pci_addr == '0)); // R11

   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_rd) |-> reg_rdata == '0); // R10

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> win_en == '0); // R7

endmodule

bind obwin_xlate obwin_xlate_chk #(.NWIN(NWIN), .DW(DW), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
   .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pci_addr(lk_pci_addr),
   .win_en(win_en), .win_hit(win_hit)
);

// File: tb/obwin_xlate_bench.sv
`timescale 1ns/100ps
module obwin_xlate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] lk_addr = '0;
   logic        lk_hit;
   logic [1:0]  lk_idx;
   logic [63:0] lk_pci_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [63:0] m_loc [3];
   logic [63:0] m_pci [3];
   logic [31:0] m_ctl [3];
   logic [31:0] exp_rd = '0;
   string       exp_tag = "R10";
   logic [63:0] cur_la = '0;

   always #2.5 clk = ~clk;

   obwin_xlate u_obwin_xlate (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pci_addr(lk_pci_addr)
   );

   // ---------------- reference model ----------------
   task automatic m_reset();
      for (int w = 0; w < 3; w++) begin
         m_loc[w] = '0; m_pci[w] = '0; m_ctl[w] = '0;
      end
   endtask

   task automatic m_write(input logic [7:0] a, input logic [31:0] d);
      for (int w = 0; w < 2; w++) begin
         int b;
         b = 'h68 + 'h14 * w;
         if (a == b)      m_loc[w][31:0]  = d;
         if (a == b + 4)  m_loc[w][63:32] = d;
         if (a == b + 8)  m_ctl[w]        = d;
         if (a == b + 12) m_pci[w][31:0]  = d;
         if (a == b + 16) m_pci[w][63:32] = d;
      end
      if (a == 8'h90) m_ctl[2] = d;
   endtask

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [31:0] v;
      v = '0;
      for (int w = 0; w < 2; w++) begin
         int b;
         b = 'h68 + 'h14 * w;
         if (a == b)      v = m_loc[w][31:0];
         if (a == b + 4)  v = m_loc[w][63:32];
         if (a == b + 8)  v = m_ctl[w];
         if (a == b + 12) v = m_pci[w][31:0];
         if (a == b + 16) v = m_pci[w][63:32];
      end
      if (a == 8'h90) v = m_ctl[2];
      return v;
   endfunction

   task automatic m_look(input logic [63:0] a, output logic h, output int ix,
                         output logic [63:0] pa);
      h = 1'b0; ix = 0; pa = '0;
      for (int w = 2; w >= 0; w--) begin
         logic [63:0] span;
         logic [63:0] off;
         span = 64'h1_0000_0000 - {32'h0, m_ctl[w] & 32'hFFFF_FFFE};
         off  = a - m_loc[w];
         if (m_ctl[w][0] && off < span) begin
            h = 1'b1; ix = w; pa = m_pci[w] + off;
         end
      end
   endtask

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, compare against the model state
   task automatic cyc(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d,
                      input logic [63:0] la, input string tag);
      logic h; int ix; logic [63:0] pa;
      @(negedge clk);
      reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; lk_addr = la;
      #1;
      m_look(la, h, ix, pa);
      chk({tag, " hit"}, 64'(lk_hit), 64'(h));
      chk({tag, " idx"}, 64'(lk_idx), 64'(ix));
      chk({tag, " pci"}, lk_pci_addr, pa);
      chk({exp_tag, " rdata"}, 64'(reg_rdata), 64'(exp_rd));
      exp_rd  = r ? m_read(a) : 32'h0;
      exp_tag = r ? tag : "R10";
      if (w) m_write(a, d);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      cyc(1'b1, 1'b0, a, d, cur_la, tag);
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      cyc(1'b0, 1'b1, a, 32'h0, cur_la, tag);
   endtask

   task automatic look(input logic [63:0] la, input string tag);
      cur_la = la;
      cyc(1'b0, 1'b0, 8'h00, 32'h0, la, tag);
   endtask

   task automatic rd_all(input string tag);
      int offs [11] = '{'h68, 'h6C, 'h70, 'h74, 'h78, 'h7C, 'h80, 'h84, 'h88, 'h8C, 'h90};
      for (int i = 0; i < 11; i++) rd(8'(offs[i]), tag);
      look(cur_la, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
      repeat (3) @(negedge clk);
      m_reset();
      exp_rd = '0;
      exp_tag = "R7";
      rst_n = 1'b1;
   endtask

   // ---------------- stimulus ----------------
   initial begin
      m_reset();
      do_reset();

      // R7: reset state
      look(64'h0, "R7");
      look(64'h1_8000_0000, "R7");
      rd_all("R7");

      // R1: every register stores and reads back, windows left disabled
      wr(8'h68, 32'h1111_1110, "R1"); wr(8'h6C, 32'h2222_2222, "R1");
      wr(8'h70, 32'hFF00_0000, "R1"); wr(8'h74, 32'h3333_3330, "R1");
      wr(8'h78, 32'h4444_4444, "R1"); wr(8'h7C, 32'h5555_5550, "R1");
      wr(8'h80, 32'h6666_6666, "R1"); wr(8'h84, 32'hFFF0_0000, "R1");
      wr(8'h88, 32'h7777_7770, "R1"); wr(8'h8C, 32'h8888_8888, "R1");
      wr(8'h90, 32'hF000_0000, "R1");
      rd_all("R1");
      look(64'h2222_2222_1111_1110, "R3");

      // R2: half writes keep the other half
      wr(8'h6C, 32'h0000_0001, "R2");
      rd(8'h68, "R2"); rd(8'h6C, "R2");
      wr(8'h74, 32'hC000_0000, "R2");
      rd(8'h74, "R2"); rd(8'h78, "R2");
      wr(8'h68, 32'h8000_0000, "R2");
      wr(8'h78, 32'h0000_0000, "R2");
      rd(8'h68, "R2"); rd(8'h6C, "R2"); rd(8'h78, "R2");

      // R6: enable takes effect on the next lookup; R4/R5 edges
      look(64'h1_8000_0000, "R3");
      wr(8'h70, 32'hFFFF_0001, "R6");
      look(64'h1_8000_0000, "R6");
      look(64'h1_8000_FFFF, "R4");
      look(64'h1_8001_0000, "R4");
      look(64'h1_7FFF_FFFF, "R5");
      look(64'h1_8000_1234, "R5");
      look(64'h0000_0000_0000_0042, "R11");

      // R8: overlapping window 1, lower index wins
      wr(8'h7C, 32'h8000_8000, "R8"); wr(8'h80, 32'h0000_0001, "R8");
      wr(8'h88, 32'h0000_0000, "R8"); wr(8'h8C, 32'h0000_0002, "R8");
      wr(8'h84, 32'hFFFF_F001, "R8");
      look(64'h1_8000_8010, "R8");
      look(64'h1_8000_8FFF, "R8");
      // R3: disabling window 0 hands the overlap to window 1
      wr(8'h70, 32'hFFFF_0000, "R3");
      look(64'h1_8000_8010, "R3");
      look(64'h1_8000_0010, "R3");
      look(64'h1_8000_9000, "R4");

      // R5: size-only window with zero bases
      wr(8'h90, 32'hF000_0001, "R5");
      look(64'h0800_1234, "R5");
      look(64'h0FFF_FFFF, "R4");
      look(64'h1000_0000, "R4");

      // R4: zero mask spans 4 GiB
      wr(8'h84, 32'h0000_0001, "R4");
      look(64'h2_8000_7FFF, "R4");
      look(64'h2_8000_8000, "R4");
      look(64'h1_8000_7FFF, "R4");

      // R5: window wrapping past the top of the 64-bit space
      wr(8'h68, 32'hFFFF_F000, "R5"); wr(8'h6C, 32'hFFFF_FFFF, "R5");
      wr(8'h74, 32'h0000_0000, "R5"); wr(8'h78, 32'h0000_0010, "R5");
      wr(8'h70, 32'hFFFF_E001, "R5");
      look(64'hFFFF_FFFF_FFFF_F000, "R5");
      look(64'h0000_0000_0000_0800, "R8");
      look(64'h0000_0000_0000_1000, "R5");
      look(64'hFFFF_FFFF_FFFF_EFFF, "R5");

      // R9: unmapped offsets
      wr(8'h94, 32'hFFFF_FFFF, "R9"); wr(8'h00, 32'hFFFF_FFFF, "R9");
      wr(8'h64, 32'hFFFF_FFFF, "R9"); wr(8'h6A, 32'hFFFF_FFFF, "R9");
      wr(8'hFC, 32'hFFFF_FFFF, "R9");
      rd(8'h94, "R9"); rd(8'h00, "R9"); rd(8'h6A, "R9"); rd(8'hFC, "R9");
      rd_all("R9");
      look(64'h0000_0000_0000_0800, "R9");
      look(64'h2_8000_8000, "R9");

      // R5: lookups scattered around the window bases
      for (int i = 0; i < 200; i++) begin
         logic [63:0] a;
         a = m_loc[i % 3] + 64'($urandom_range(0, 'h3_FFFF)) - 64'h2_0000;
         look(a, "R5");
      end

      // R7: reset in mid-run clears everything
      do_reset();
      look(64'h0000_0000_0000_0800, "R7");
      rd_all("R7");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R10 act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule